// File: doc/BRIEF.md
# Key-Protected System Control Registers

This block is a bank of 32-bit control and status words behind a simple word-aligned bus. The bus has a write strobe, a read strobe, a byte address, write data and registered read data. Most of the lower control space is guarded by a key word. Writes there take effect only while the key word holds one exact 32-bit unlock value. Writing any other value to the key word closes the guard again.

A few words are read-only. The revision word and the two strap words are loaded from input pins during reset. Two counter words always read their live input pins. At reset the whole bank loads a default image. The image depends on which family the revision input code belongs to.

Every access the bank refuses or flags produces a one-cycle error pulse with a kind code. Flagged cases are an address past the end of the bank, a write stopped by the guard, a write to a read-only word, and a read of the write-only wake word. The bank only holds values and drives no clock, reset or pin hardware.

Top module: `keyreg_ctrl`

## Requirements
- R1: The word index is the byte address shifted right by two. Read data appears on the cycle after the read strobe. A write and a read of the same word in the same cycle return the value held before the write.
- R2: With the default 106 words, any word index of 106 or more reads as 0 and ignores writes. Such an access raises error kind 0.
- R3: A write to byte offsets 0x004 through 0x100 is dropped while the key word at offset 0x000 is not exactly 0x1688A8A8. A dropped write raises error kind 1.
- R4: The key word at 0x000, and every word at 0x104 and above, accept writes whatever the guard state.
- R5: Writes are dropped to these read-only words: 0x014, 0x050 to 0x06C, 0x078, 0x07C, 0x0E0 and 0x0E4. When the guard is open, such a write raises error kind 2.
- R6: Words 0x0E0 and 0x0E4 read the current values of `cnt_lo` and `cnt_hi`.
- R7: A read of the wake word at 0x0C0 returns its stored value and raises error kind 3.
- R8: `err_pulse` is high for exactly one cycle, aligned with read data, after each flagged access. `err_kind` is valid while it is high. When several cases apply, the order is: out of range, then guard, then read-only, then write-only read. A write in the same cycle as a read takes precedence over the read.
- R9: After reset, the key word reads 0, so the guard is closed. Word 0x004 reads 0xFFCFFEDC and word 0x03C reads 1. Word 0x024 reads 0x00000291 for the older family and 0x93000400 for the newer family.
- R10: During reset, word 0x07C loads `rev_code`, word 0x070 loads `strap_a` and word 0x0D0 loads `strap_b`.
- R11: Revision codes 0x02000303 and 0x02010303 select the older family. Codes 0x04000303 and 0x04010303 select the newer family. Any other code during reset trips a simulation assertion and falls back to the older family.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the default image |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| rev_code | input | 32 | Revision code, loaded at reset, selects the family |
| strap_a | input | 32 | First strap word, loaded at reset |
| strap_b | input | 32 | Second strap word, loaded at reset |
| cnt_lo | input | 32 | Live counter, low word |
| cnt_hi | input | 32 | Live counter, high word |
| bus_rdata | output | 32 | Registered read data |
| err_pulse | output | 1 | One-cycle error flag |
| err_kind | output | 2 | Error kind: 0 range, 1 guard, 2 read-only, 3 write-only read |

## Verification
Directed sequences first try a guarded word with the key closed, then the same word with the key open. This separates a dropped write from a missing guard. Writes to read-only words are tried with the key both open and closed, which tests the error priority order. Reads at index 106, at a far index and at the wake word separate the range check from the write-only check. Write and read to one word in the same cycle show whether read data is taken before or after the update. A reset with each of the four revision codes tells the two default images apart. A constrained random run mixes key writes and random indices, and checks each read against a bench model that tracks only words with known contents.

// File: rtl/keyreg_pkg.sv
package keyreg_pkg;

    localparam int WORD_W = 32;

    localparam logic [WORD_W-1:0] UNLOCK_WORD = 32'h1688A8A8;

    localparam logic [WORD_W-1:0] REV_OLD_A = 32'h02000303;
    localparam logic [WORD_W-1:0] REV_OLD_B = 32'h02010303;
    localparam logic [WORD_W-1:0] REV_NEW_A = 32'h04000303;
    localparam logic [WORD_W-1:0] REV_NEW_B = 32'h04010303;

    // word indices whose position the behaviour depends on
    localparam int IDX_KEY       = 0;
    localparam int IDX_ZONE_LAST = 64;   // 0x100, last guarded word
    localparam int IDX_STRAP_A   = 28;   // 0x070
    localparam int IDX_REV       = 31;   // 0x07C
    localparam int IDX_WAKE      = 48;   // 0x0C0
    localparam int IDX_STRAP_B   = 52;   // 0x0D0
    localparam int IDX_CNT_LO    = 56;   // 0x0E0
    localparam int IDX_CNT_HI    = 57;   // 0x0E4

    typedef enum logic [1:0] {
        ERR_RANGE    = 2'd0,
        ERR_LOCKED   = 2'd1,
        ERR_READONLY = 2'd2,
        ERR_WONLY    = 2'd3
    } err_kind_e;

    function automatic logic is_readonly(input int unsigned idx);
        return (idx == 5) || (idx >= 20 && idx <= 27) || (idx == 30) ||
               (idx == 31) || (idx == 56) || (idx == 57);
    endfunction

    function automatic logic rev_known(input logic [WORD_W-1:0] code);
        return (code == REV_OLD_A) || (code == REV_OLD_B) ||
               (code == REV_NEW_A) || (code == REV_NEW_B);
    endfunction

    function automatic logic rev_newer(input logic [WORD_W-1:0] code);
        return (code == REV_NEW_A) || (code == REV_NEW_B);
    endfunction

    // reset image; words not listed reset to zero
    function automatic logic [WORD_W-1:0] default_word(input int unsigned idx,
                                                       input logic newer);
        case (idx)
            1:       return 32'hFFCFFEDC;
            2:       return 32'hF3F40000;
            3:       return 32'h19FC3E8B;
            9:       return newer ? 32'h93000400 : 32'h00000291;
            11:      return 32'h00000010;
            15:      return 32'h00000001;
            16:      return 32'h000000C0;
            19:      return 32'h00000023;
            29:      return 32'h0000000E;
            35:      return newer ? 32'h00000000 : 32'h000000FF;
            39:      return newer ? 32'h023FFFF3 : 32'h003FFFF3;
            65:      return 32'h80000000;
            68:      return 32'h1E600000;
            105:     return 32'h00002402;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/keyreg_decode.sv
module keyreg_decode
    import keyreg_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 106,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic             we,
    input  logic             re,
    input  logic [ADDR_W-1:0] addr,
    input  logic             unlocked,
    output logic [IDX_W-1:0] idx,
    output logic             in_range,
    output logic             wr_ok,
    output logic             live_lo,
    output logic             live_hi,
    output logic             err_hit,
    output err_kind_e        err_kind
);

    logic zone;
    logic ro;

    always_comb begin
        idx      = addr[ADDR_W-1:2];
        in_range = idx < IDX_W'(NUM_REGS);
        zone     = (idx >= IDX_W'(1)) && (idx <= IDX_W'(IDX_ZONE_LAST));
        ro       = is_readonly(int'(idx));
        live_lo  = idx == IDX_W'(IDX_CNT_LO);
        live_hi  = idx == IDX_W'(IDX_CNT_HI);
        wr_ok    = we && in_range && !(zone && !unlocked) && !ro;

        err_hit  = 1'b0;
        err_kind = ERR_RANGE;
        if ((we || re) && !in_range) begin
            err_hit  = 1'b1;
            err_kind = ERR_RANGE;
        end else if (we) begin
            if (zone && !unlocked) begin
                err_hit  = 1'b1;
                err_kind = ERR_LOCKED;
            end else if (ro) begin
                err_hit  = 1'b1;
                err_kind = ERR_READONLY;
            end
        end else if (re && idx == IDX_W'(IDX_WAKE)) begin
            err_hit  = 1'b1;
            err_kind = ERR_WONLY;
        end
    end

endmodule

// File: rtl/keyreg_store.sv
module keyreg_store
    import keyreg_pkg::*;
#(
    parameter int NUM_REGS = 106,
    parameter int IDX_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rev_code,
    input  logic [WORD_W-1:0] strap_a,
    input  logic [WORD_W-1:0] strap_b,
    input  logic              wr_ok,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_word,
    output logic              unlocked
);

    typedef logic [NUM_REGS-1:0][WORD_W-1:0] bank_t;

    bank_t regs_d, regs_q;
    logic  newer;

    always_comb begin
        newer  = rev_newer(rev_code);
        regs_d = regs_q;
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_d[i] = default_word(i, newer);
            end
            regs_d[IDX_REV]     = rev_code;
            regs_d[IDX_STRAP_A] = strap_a;
            regs_d[IDX_STRAP_B] = strap_b;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_ok && idx == IDX_W'(i)) begin
                    regs_d[i] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_word = regs_q[i];
            end
        end
        unlocked = regs_q[IDX_KEY] == UNLOCK_WORD;
    end

    AST_REV_KNOWN: assert property (@(posedge clk)
        !rst_n |-> rev_known(rev_code)); // R11

    AST_REV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(regs_q[IDX_REV])); // R5

endmodule

// File: rtl/keyreg_resp.sv
module keyreg_resp
    import keyreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic              in_range,
    input  logic              live_lo,
    input  logic              live_hi,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [WORD_W-1:0] cnt_lo,
    input  logic [WORD_W-1:0] cnt_hi,
    input  logic              err_hit,
    input  err_kind_e         err_kind,
    output logic [WORD_W-1:0] rdata,
    output logic              err_pulse,
    output err_kind_e         err_code
);

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic              err;
        err_kind_e         kind;
    } resp_t;

    resp_t resp_d, resp_q;

    always_comb begin
        resp_d      = resp_q;
        resp_d.err  = err_hit;
        resp_d.kind = err_kind;
        if (re) begin
            if (!in_range)    resp_d.rdata = '0;
            else if (live_lo) resp_d.rdata = cnt_lo;
            else if (live_hi) resp_d.rdata = cnt_hi;
            else              resp_d.rdata = rd_word;
        end
        if (!rst_n) begin
            resp_d = '{rdata: '0, err: 1'b0, kind: ERR_RANGE};
        end
    end

    always_ff @(posedge clk) begin
        resp_q <= resp_d;
    end

    assign rdata     = resp_q.rdata;
    assign err_pulse = resp_q.err;
    assign err_code  = resp_q.kind;

    AST_RANGE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (re && !in_range) |=> (rdata == '0)); // R2

endmodule

// File: rtl/keyreg_ctrl.sv
module keyreg_ctrl
    import keyreg_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 106,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] rev_code,
    input  logic [WORD_W-1:0] strap_a,
    input  logic [WORD_W-1:0] strap_b,
    input  logic [WORD_W-1:0] cnt_lo,
    input  logic [WORD_W-1:0] cnt_hi,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              err_pulse,
    output logic [1:0]        err_kind
);

    logic [IDX_W-1:0]  idx;
    logic              in_range;
    logic              wr_ok;
    logic              live_lo;
    logic              live_hi;
    logic              err_hit;
    err_kind_e         hit_kind;
    err_kind_e         err_code;
    logic [WORD_W-1:0] rd_word;
    logic              unlocked;

    keyreg_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
        .we       (bus_we),
        .re       (bus_re),
        .addr     (bus_addr),
        .unlocked (unlocked),
        .idx      (idx),
        .in_range (in_range),
        .wr_ok    (wr_ok),
        .live_lo  (live_lo),
        .live_hi  (live_hi),
        .err_hit  (err_hit),
        .err_kind (hit_kind)
    );

    keyreg_store #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rev_code (rev_code),
        .strap_a  (strap_a),
        .strap_b  (strap_b),
        .wr_ok    (wr_ok),
        .idx      (idx),
        .wdata    (bus_wdata),
        .rd_word  (rd_word),
        .unlocked (unlocked)
    );

    keyreg_resp u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .re        (bus_re),
        .in_range  (in_range),
        .live_lo   (live_lo),
        .live_hi   (live_hi),
        .rd_word   (rd_word),
        .cnt_lo    (cnt_lo),
        .cnt_hi    (cnt_hi),
        .err_hit   (err_hit),
        .err_kind  (hit_kind),
        .rdata     (bus_rdata),
        .err_pulse (err_pulse),
        .err_code  (err_code)
    );

    assign err_kind = err_code;

    AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !unlocked && bus_addr[ADDR_W-1:2] >= IDX_W'(1) &&
         bus_addr[ADDR_W-1:2] <= IDX_W'(IDX_ZONE_LAST))
        |=> (err_pulse && err_kind == 2'd1)); // R3

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(bus_we || bus_re)); // R8

    AST_KEY_RESET: assert property (@(posedge clk)
        !rst_n |=> !unlocked); // R9

endmodule

// File: tb/tb_keyreg_ctrl.sv
module tb_keyreg_ctrl;

    localparam int NREG = 106;
    localparam logic [31:0] UNLK = 32'h1688A8A8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rev_code = 32'h02000303;
    logic [31:0] strap_a = '0;
    logic [31:0] strap_b = '0;
    logic [31:0] cnt_lo = '0;
    logic [31:0] cnt_hi = '0;
    logic [31:0] bus_rdata;
    logic        err_pulse;
    logic [1:0]  err_kind;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [31:0] model [0:1023];
    bit          known [0:1023];

    always #10 clk = ~clk;

    keyreg_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rev_code(rev_code),
        .strap_a(strap_a), .strap_b(strap_b), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .bus_rdata(bus_rdata), .err_pulse(err_pulse), .err_kind(err_kind)
    );

    function automatic bit ro_word(input int idx);
        return idx == 5 || (idx >= 20 && idx <= 27) || idx == 30 ||
               idx == 31 || idx == 56 || idx == 57;
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [31:0] rev, input logic [31:0] sa,
                            input logic [31:0] sb);
        bit newer;
        @(negedge clk);
        rst_n = 1'b0; rev_code = rev; strap_a = sa; strap_b = sb;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        newer = (rev == 32'h04000303) || (rev == 32'h04010303);
        for (int i = 0; i < 1024; i++) begin
            known[i] = 0;
            model[i] = '0;
        end
        known[0] = 1;
        model[1] = 32'hFFCFFEDC; known[1] = 1;
        model[9] = newer ? 32'h93000400 : 32'h00000291; known[9] = 1;
        model[15] = 32'h1; known[15] = 1;
        model[28] = sa; known[28] = 1;
        model[52] = sb; known[52] = 1;
        model[31] = rev; known[31] = 1;
        for (int i = 0; i < 64; i++) if (ro_word(i)) known[i] = 1;
        check("R9 reset rdata", bus_rdata, 32'h0);
        check("R8 reset err", {31'b0, err_pulse}, 32'h0);
    endtask

    task automatic op(input bit we, input bit re, input int idx,
                      input logic [31:0] wd, input string req);
        bit unl, inr, zone, hit, wok, rk;
        logic [1:0] kind;
        logic [31:0] exp_rd;
        unl  = model[0] == UNLK;
        inr  = idx < NREG;
        zone = idx >= 1 && idx <= 64;
        hit = 0; kind = 2'd0;
        if ((we || re) && !inr) begin hit = 1; kind = 2'd0; end
        else if (we) begin
            if (zone && !unl) begin hit = 1; kind = 2'd1; end
            else if (ro_word(idx)) begin hit = 1; kind = 2'd2; end
        end else if (re && idx == 48) begin hit = 1; kind = 2'd3; end
        wok = we && inr && !(zone && !unl) && !ro_word(idx);
        rk = 1;
        if (!inr) exp_rd = '0;
        else if (idx == 56) exp_rd = cnt_lo;
        else if (idx == 57) exp_rd = cnt_hi;
        else begin exp_rd = model[idx]; rk = known[idx]; end

        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = 12'(idx << 2); bus_wdata = wd;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
        check({req, " err_pulse"}, {31'b0, err_pulse}, {31'b0, hit});
        if (hit) check({req, " err_kind"}, {30'b0, err_kind}, {30'b0, kind});
        if (re && rk) check({req, " rdata"}, bus_rdata, exp_rd);
        if (wok) begin model[idx] = wd; known[idx] = 1; end
    endtask

    initial begin
        #4000000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset(32'h02000303, 32'hA5A50F0F, 32'h12345678);

        op(0, 1, 1,  0, "R9 rst ctl default");
        op(0, 1, 9,  0, "R9 older pll default");
        op(0, 1, 15, 0, "R9 status default");
        op(0, 1, 0,  0, "R9 key reset zero");
        op(0, 1, 31, 0, "R10 revision word");
        op(0, 1, 28, 0, "R10 strap a");
        op(0, 1, 52, 0, "R10 strap b");

        op(1, 0, 1, 32'hDEADBEEF, "R3 locked write");
        op(0, 1, 1, 0, "R3 locked value kept");
        op(1, 0, 64, 32'h11111111, "R3 last guarded word");
        op(0, 1, 64, 0, "R3 last guarded readback");
        op(1, 0, 65, 32'h0BADF00D, "R4 upper write locked");
        op(0, 1, 65, 0, "R4 upper readback");
        op(1, 0, 0, 32'h1688A8A9, "R4 key near miss");
        op(1, 0, 2, 32'h55AA55AA, "R3 near miss still locked");
        op(1, 0, 0, UNLK, "R4 key unlock");
        op(1, 0, 1, 32'hCAFE0001, "R3 unlocked write");
        op(0, 1, 1, 0, "R3 unlocked readback");

        op(1, 0, 31, 32'hFFFFFFFF, "R5 revision write");
        op(0, 1, 31, 0, "R5 revision kept");
        op(1, 0, 20, 32'h77777777, "R5 scratch write");
        op(0, 1, 20, 0, "R5 scratch kept");
        op(1, 0, 5, 32'h1, "R5 freq result write");

        cnt_lo = 32'h00C0FFEE; cnt_hi = 32'h0000BEEF;
        op(0, 1, 56, 0, "R6 live low");
        op(0, 1, 57, 0, "R6 live high");
        cnt_lo = 32'h12121212;
        op(0, 1, 56, 0, "R6 live low changed");

        op(1, 0, 48, 32'h00000F0F, "R7 wake write");
        op(0, 1, 48, 0, "R7 wake read flags");

        op(1, 1, 106, 32'h9, "R2 first out of range");
        op(0, 1, 106, 0, "R2 out of range read");
        op(1, 0, 300, 32'h9, "R2 far write");
        op(0, 1, 1023, 0, "R2 last window word");

        op(1, 1, 70, 32'h13579BDF, "R1 same cycle old value");
        op(0, 1, 70, 0, "R1 new value after");

        op(1, 0, 0, 32'h0, "R8 relock");
        op(1, 0, 5, 32'h3, "R8 guard before read-only");
        op(1, 1, 48, 32'h2, "R8 write over read locked");

        do_reset(32'h04000303, 32'h0, 32'hFFFFFFFF);
        op(0, 1, 9, 0, "R11 newer code A pll");
        op(0, 1, 39, 0, "R11 newer wake reset word unknown");
        do_reset(32'h04010303, 32'h1, 32'h2);
        op(0, 1, 9, 0, "R11 newer code B pll");
        do_reset(32'h02010303, 32'h3, 32'h4);
        op(0, 1, 9, 0, "R11 older code B pll");
        op(0, 1, 31, 0, "R10 revision after older B");

        for (int n = 0; n < 600; n++) begin
            int idx;
            bit we, re;
            logic [31:0] wd;
            idx = int'($urandom % 128);
            if ($urandom % 8 == 0) idx = 0;
            we = $urandom % 2;
            re = $urandom % 2;
            if (!we && !re) re = 1;
            wd = $urandom;
            if (idx == 0 && ($urandom % 2)) wd = UNLK;
            if ($urandom % 16 == 0) begin
                cnt_lo = $urandom; cnt_hi = $urandom;
            end
            op(we, re, idx, wd, "R1 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule